// File: doc/BRIEF.md
# Receiver Collision Request-Grant Controller

This controller sits in one node of a slotted multi-wavelength ring. Several transmitters on different wavelengths can aim at the same receiver, and that receiver can take only one of them at a time. The controller measures how long the node's head packet for one destination has been blocked. When the wait grows too long, the controller writes a request into the collision-address field of the passing slot header, naming the starved destination. The node then becomes the tail of a congestion path.

The other nodes relay three control messages: request, satisfied and grant. When a node sees a request, it enters a limited mode. In that mode its traffic to the named heavy sink is capped at a fixed quota, and traffic to every other destination stays unrestricted. The satisfied message travels like a token. A limited node that is still spending its quota holds the token, and it passes the token on once it becomes inactive. When the token reaches the tail node, the tail issues a grant, and the grant returns every node it passes back to free access.

The surrounding logic presents one slot per `slot_vld` strobe. For that slot it supplies the incoming control field and the node's transmit status. The controller answers with the control field to write into the outgoing slot, together with its mode, the heavy-sink address, the remaining quota and a permit for heavy-sink traffic.

Top module: `rgc_ctrl`

## Requirements
- R1: After reset the node is in free access: `limited`=0, `tail`=0, `hs_addr`=0, `quota_left`=0, `hs_ok`=1 and `tx_msg`=00.
- R2: Control messages are coded on 2 bits as 00 none, 01 request, 10 grant and 11 satisfied. `tx_msg`/`tx_addr` are registered and reflect the slot presented in the previous cycle. A cycle without `slot_vld` yields `tx_msg`=00 and `tx_addr`=0.
- R3: In free access, every slot with `blk_wait`=1 adds one to a contiguous-delay count. A successful send to `blk_dst` clears the count. When the count already equals QD, a waiting slot whose incoming field is empty makes the node emit a request carrying `blk_dst`, enter the tail state with `hs_addr`=`blk_dst` and `quota_left`=QUOTA, and clear the count.
- R4: A slot with neither a wait nor a successful send to `blk_dst` leaves the delay count unchanged.
- R5: An incoming request in free access puts the node in limited mode (`tail`=0). The node records the carried address, loads the quota, forwards the request and clears its delay count. The incoming request takes precedence over the node's own threshold crossing in the same slot.
- R6: If the count has reached QD but the incoming field is occupied by a message other than a request, that message is forwarded and the node's own request waits, with the count held, until a waiting slot with an empty field arrives.
- R7: While limited or tail, each send to `hs_addr` lowers `quota_left` by one, stopping at zero. `hs_ok` is 0 exactly when the node is limited or tail and its quota is zero.
- R8: A limited node that receives satisfied for `hs_addr` forwards it at once if it is inactive (quota zero or `hs_pend`=0). Otherwise it holds the message and emits satisfied for `hs_addr` on the first empty-field slot in which it is inactive.
- R9: A tail node receiving satisfied for `hs_addr` emits a grant for that address and returns to free access with address and quota cleared.
- R10: A grant for `hs_addr` received while limited or tail returns the node to free access, clears `hs_addr` and `quota_left`, and is forwarded.
- R11: Any incoming message not consumed by R5, R8, R9 or R10 is forwarded with its type and address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_vld | input | 1 | A slot is presented this cycle |
| rx_msg | input | 2 | Incoming control message type |
| rx_addr | input | AW | Incoming collision address |
| blk_wait | input | 1 | Head packet for `blk_dst` could not be sent in this slot |
| blk_dst | input | AW | Destination of the blocked head packet |
| tx_done | input | 1 | Node sent a packet in this slot |
| tx_dst | input | AW | Destination of the packet sent |
| hs_pend | input | 1 | Queue holds packets for `hs_addr` |
| tx_msg | output | 2 | Outgoing control message type |
| tx_addr | output | AW | Outgoing collision address |
| limited | output | 1 | Node is in limited mode (including tail) |
| tail | output | 1 | Node originated the current congestion path |
| hs_addr | output | AW | Recorded heavy-sink address |
| quota_left | output | QW | Remaining heavy-sink quota |
| hs_ok | output | 1 | Sending to the heavy sink is permitted |

## Verification
The sharpest overlap occurs when the node's own delay count crosses its threshold in the same slot that a request from upstream arrives. The bench provokes this by holding a blocked head packet for QD slots and then presenting a request together with a further wait. The expected result is that the upstream address is recorded, no tail state is entered, the request is forwarded and the count restarts from zero. That restart is confirmed by counting a fresh run of QD+1 waits before the node's own request finally appears. A second overlap, in which the threshold meets an occupied field carrying satisfied, is judged by the forwarded token followed by the deferred request in the next waiting slot.

// File: rtl/rgc_pkg.sv
package rgc_pkg;
  typedef enum logic [1:0] {
    MSG_NONE = 2'b00,
    MSG_REQ  = 2'b01,
    MSG_GNT  = 2'b10,
    MSG_SAT  = 2'b11
  } msg_e;

  typedef enum logic [1:0] {
    ST_FREE  = 2'd0,
    ST_LIMIT = 2'd1,
    ST_TAIL  = 2'd2
  } mode_e;
endpackage

// File: rtl/rgc_starve_mon.sv
module rgc_starve_mon #(
  parameter int QD = 3,
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          slot_vld,
  input  logic          clr,
  input  logic          blk_wait,
  input  logic          arm,
  output logic          fire,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] LIMIT = CW'(QD);

  assign fire = slot_vld && !clr && blk_wait && arm && (count == LIMIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (slot_vld) begin
      if (clr || fire)
        count <= '0;
      else if (blk_wait && count < LIMIT)
        count <= count + 1'b1;
    end
  end

  // R6
  count_cap_chk: assert property (@(posedge clk) disable iff (rst)
    count <= LIMIT);

  // R3
  fire_clears_chk: assert property (@(posedge clk) disable iff (rst)
    fire |=> count == '0);
endmodule

// File: rtl/rgc_quota.sv
module rgc_quota #(
  parameter int QUOTA = 2,
  parameter int QW    = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          clr,
  input  logic          dec,
  output logic [QW-1:0] q
);
  localparam logic [QW-1:0] FULL = QW'(QUOTA);

  always_ff @(posedge clk) begin
    if (rst)
      q <= '0;
    else if (clr)
      q <= '0;
    else if (load)
      q <= FULL;
    else if (dec && q != '0)
      q <= q - 1'b1;
  end

  // R7
  quota_cap_chk: assert property (@(posedge clk) disable iff (rst)
    q <= FULL);
endmodule

// File: rtl/rgc_ctrl.sv
module rgc_ctrl
  import rgc_pkg::*;
#(
  parameter int AW    = 4,
  parameter int QD    = 3,
  parameter int QUOTA = 2,
  localparam int CW   = $clog2(QD + 1),
  localparam int QW   = $clog2(QUOTA + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          slot_vld,
  input  logic [1:0]    rx_msg,
  input  logic [AW-1:0] rx_addr,
  input  logic          blk_wait,
  input  logic [AW-1:0] blk_dst,
  input  logic          tx_done,
  input  logic [AW-1:0] tx_dst,
  input  logic          hs_pend,
  output logic [1:0]    tx_msg,
  output logic [AW-1:0] tx_addr,
  output logic          limited,
  output logic          tail,
  output logic [AW-1:0] hs_addr,
  output logic [QW-1:0] quota_left,
  output logic          hs_ok
);
  mode_e         state, n_state;
  logic [AW-1:0] hs_q, n_hs;
  logic          held_q, n_held;
  msg_e          rx, o_msg;
  logic [AW-1:0] o_addr, fwd_addr;
  logic          match, inactive, hs_send, success;
  logic          cnt_clr, arm, fire;
  logic          q_load, q_clr, q_dec;
  logic [CW-1:0] count;
  logic [QW-1:0] quota;

  always_comb begin
    rx       = msg_e'(rx_msg);
    match    = (rx_addr == hs_q);
    inactive = (quota == '0) || !hs_pend;
    hs_send  = tx_done && (tx_dst == hs_q);
    success  = tx_done && (tx_dst == blk_dst);
    cnt_clr  = (state != ST_FREE) || success || (rx == MSG_REQ);
    arm      = (state == ST_FREE) && (rx == MSG_NONE);
    fwd_addr = (rx == MSG_NONE) ? '0 : rx_addr;
  end

  rgc_starve_mon #(.QD(QD), .CW(CW)) u_mon (
    .clk(clk), .rst(rst), .slot_vld(slot_vld), .clr(cnt_clr),
    .blk_wait(blk_wait), .arm(arm), .fire(fire), .count(count)
  );

  rgc_quota #(.QUOTA(QUOTA), .QW(QW)) u_quota (
    .clk(clk), .rst(rst), .load(q_load), .clr(q_clr), .dec(q_dec), .q(quota)
  );

  always_comb begin
    n_state = state;
    n_hs    = hs_q;
    n_held  = held_q;
    o_msg   = MSG_NONE;
    o_addr  = '0;
    q_load  = 1'b0;
    q_clr   = 1'b0;
    q_dec   = slot_vld && (state != ST_FREE) && hs_send;
    if (slot_vld) begin
      if (state == ST_FREE) begin
        if (rx == MSG_REQ) begin
          n_state = ST_LIMIT;
          n_hs    = rx_addr;
          q_load  = 1'b1;
          o_msg   = MSG_REQ;
          o_addr  = rx_addr;
        end else if (fire) begin
          n_state = ST_TAIL;
          n_hs    = blk_dst;
          q_load  = 1'b1;
          o_msg   = MSG_REQ;
          o_addr  = blk_dst;
        end else begin
          o_msg   = rx;
          o_addr  = fwd_addr;
        end
      end else begin
        if (rx == MSG_GNT && match) begin
          n_state = ST_FREE;
          n_hs    = '0;
          n_held  = 1'b0;
          q_clr   = 1'b1;
          o_msg   = MSG_GNT;
          o_addr  = rx_addr;
        end else if (rx == MSG_SAT && match) begin
          if (state == ST_TAIL) begin
            n_state = ST_FREE;
            n_hs    = '0;
            n_held  = 1'b0;
            q_clr   = 1'b1;
            o_msg   = MSG_GNT;
            o_addr  = hs_q;
          end else if (inactive) begin
            o_msg   = MSG_SAT;
            o_addr  = rx_addr;
          end else begin
            n_held  = 1'b1;
          end
        end else if (rx != MSG_NONE) begin
          o_msg   = rx;
          o_addr  = rx_addr;
        end else if (held_q && inactive && state == ST_LIMIT) begin
          n_held  = 1'b0;
          o_msg   = MSG_SAT;
          o_addr  = hs_q;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_FREE;
      hs_q    <= '0;
      held_q  <= 1'b0;
      tx_msg  <= MSG_NONE;
      tx_addr <= '0;
    end else begin
      state   <= n_state;
      hs_q    <= n_hs;
      held_q  <= n_held;
      tx_msg  <= o_msg;
      tx_addr <= o_addr;
    end
  end

  assign limited    = (state != ST_FREE);
  assign tail       = (state == ST_TAIL);
  assign hs_addr    = hs_q;
  assign quota_left = quota;
  assign hs_ok      = (state == ST_FREE) || (quota != '0);

  // R1
  free_quota_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FREE) |-> (quota == '0 && hs_q == '0));

  // R2
  idle_slot_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(slot_vld) |-> (tx_msg == MSG_NONE));

  // R3
  tail_req_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tail) |-> (tx_msg == MSG_REQ && tx_addr == hs_q));

  // R10
  gnt_return_chk: assert property (@(posedge clk) disable iff (rst)
    (slot_vld && state != ST_FREE && rx == MSG_GNT && match)
      |=> (state == ST_FREE && quota == '0));

  // R9
  tail_grant_chk: assert property (@(posedge clk) disable iff (rst)
    (slot_vld && state == ST_TAIL && rx == MSG_SAT && match)
      |=> (tx_msg == MSG_GNT && !tail));
endmodule

// File: tb/rgc_ctrl_test.sv
`timescale 1ns/1ps
module rgc_ctrl_test;
  localparam int AW = 4, QD = 3, QUOTA = 2, QW = 2;

  logic clk = 0, rst = 1;
  logic slot_vld = 0, blk_wait = 0, tx_done = 0, hs_pend = 0;
  logic [1:0] rx_msg = 0;
  logic [AW-1:0] rx_addr = 0, blk_dst = 4'd3, tx_dst = 0;
  logic [1:0] tx_msg;
  logic [AW-1:0] tx_addr, hs_addr;
  logic limited, tail, hs_ok;
  logic [QW-1:0] quota_left;

  int nchk = 0, nfail = 0;
  int m_st, m_hs, m_q, m_c, m_held, m_msg, m_addr;
  int rm, ra, nm, na;
  bit inact, shs;

  always #2 clk = ~clk;

  rgc_ctrl #(.AW(AW), .QD(QD), .QUOTA(QUOTA)) uut (
    .clk(clk), .rst(rst), .slot_vld(slot_vld), .rx_msg(rx_msg), .rx_addr(rx_addr),
    .blk_wait(blk_wait), .blk_dst(blk_dst), .tx_done(tx_done), .tx_dst(tx_dst),
    .hs_pend(hs_pend), .tx_msg(tx_msg), .tx_addr(tx_addr), .limited(limited),
    .tail(tail), .hs_addr(hs_addr), .quota_left(quota_left), .hs_ok(hs_ok)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference model
  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_hs = 0; m_q = 0; m_c = 0; m_held = 0; m_msg = 0; m_addr = 0;
    end else begin
      nm = 0; na = 0;
      if (slot_vld) begin
        rm = int'(rx_msg); ra = int'(rx_addr);
        inact = (m_q == 0) || !hs_pend;
        shs = tx_done && (int'(tx_dst) == m_hs);
        if (m_st == 0) begin
          if (rm == 1) begin
            m_st = 1; m_hs = ra; m_q = QUOTA; m_c = 0; nm = 1; na = ra;
          end else if (tx_done && tx_dst == blk_dst) begin
            m_c = 0; nm = rm; na = (rm != 0) ? ra : 0;
          end else if (blk_wait && m_c == QD && rm == 0) begin
            m_st = 2; m_hs = int'(blk_dst); m_q = QUOTA; m_c = 0; nm = 1; na = m_hs;
          end else begin
            if (blk_wait && m_c < QD) m_c++;
            nm = rm; na = (rm != 0) ? ra : 0;
          end
        end else begin
          if (shs && m_q > 0) m_q--;
          if (rm == 2 && ra == m_hs) begin
            m_st = 0; m_hs = 0; m_q = 0; m_held = 0; nm = 2; na = ra;
          end else if (rm == 3 && ra == m_hs) begin
            if (m_st == 2) begin
              nm = 2; na = m_hs; m_st = 0; m_hs = 0; m_q = 0; m_held = 0;
            end else if (inact) begin
              nm = 3; na = ra;
            end else m_held = 1;
          end else if (rm != 0) begin
            nm = rm; na = ra;
          end else if (m_held != 0 && inact) begin
            nm = 3; na = m_hs; m_held = 0;
          end
        end
      end
      m_msg = nm; m_addr = na;
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk(int'(tx_msg) == m_msg, "R2 tx_msg", int'(tx_msg), m_msg);
      chk(int'(tx_addr) == m_addr, "R11 tx_addr", int'(tx_addr), m_addr);
      chk(limited == (m_st != 0), "R5 limited", int'(limited), int'(m_st != 0));
      chk(tail == (m_st == 2), "R3 tail", int'(tail), int'(m_st == 2));
      chk(int'(hs_addr) == m_hs, "R10 hs_addr", int'(hs_addr), m_hs);
      chk(int'(quota_left) == m_q, "R7 quota", int'(quota_left), m_q);
      chk(hs_ok == (m_st == 0 || m_q != 0), "R7 hs_ok", int'(hs_ok), int'(m_st == 0 || m_q != 0));
    end
  end

  task automatic slot(input int m, input int a, input bit w, input bit d, input int td, input bit p);
    @(negedge clk);
    rx_msg = m[1:0]; rx_addr = a[AW-1:0]; blk_wait = w; tx_done = d;
    tx_dst = td[AW-1:0]; hs_pend = p; slot_vld = 1;
    @(negedge clk);
    slot_vld = 0; rx_msg = 0; rx_addr = 0; blk_wait = 0; tx_done = 0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(limited == 0 && tail == 0 && hs_addr == 0, "R1 mode", int'(limited), 0);
    chk(quota_left == 0 && hs_ok == 1 && tx_msg == 0, "R1 outputs", int'(tx_msg), 0);
    rst = 0;
    repeat (2) @(negedge clk);

    // R3 count cleared by success, R4 hold on quiet slot
    repeat (3) slot(0, 0, 1, 0, 0, 0);
    slot(0, 0, 0, 1, 3, 0);
    repeat (2) slot(0, 0, 1, 0, 0, 0);
    slot(0, 0, 0, 0, 0, 0);
    slot(0, 0, 1, 0, 0, 0);
    chk(tail == 0, "R4 no early fire", int'(tail), 0);
    slot(0, 0, 1, 0, 0, 0);
    chk(tx_msg == 2'b01 && tx_addr == 3, "R3 request out", int'(tx_msg), 1);
    chk(tail == 1 && quota_left == QUOTA, "R3 tail entry", int'(quota_left), QUOTA);

    // R7 quota consumption and floor
    slot(0, 0, 0, 1, 3, 1);
    slot(0, 0, 0, 1, 3, 1);
    chk(hs_ok == 0 && quota_left == 0, "R7 exhausted", int'(hs_ok), 0);
    slot(0, 0, 0, 1, 3, 1);
    chk(quota_left == 0, "R7 floor", int'(quota_left), 0);

    // R11 forward foreign token, R9 tail grants
    slot(3, 9, 0, 0, 0, 0);
    chk(tx_msg == 2'b11 && tx_addr == 9 && tail == 1, "R11 forward", int'(tx_addr), 9);
    slot(3, 3, 0, 0, 0, 0);
    chk(tx_msg == 2'b10 && tx_addr == 3 && limited == 0 && hs_addr == 0, "R9 grant", int'(tx_msg), 2);

    // R5 join path, R8 hold and release, R10 grant
    slot(1, 5, 0, 0, 0, 1);
    chk(limited == 1 && tail == 0 && hs_addr == 5 && tx_msg == 2'b01, "R5 join", int'(hs_addr), 5);
    slot(3, 5, 0, 0, 0, 1);
    chk(tx_msg == 0, "R8 held", int'(tx_msg), 0);
    slot(0, 0, 0, 1, 5, 1);
    slot(0, 0, 0, 1, 5, 1);
    chk(tx_msg == 0, "R8 still held", int'(tx_msg), 0);
    slot(0, 0, 0, 0, 0, 1);
    chk(tx_msg == 2'b11 && tx_addr == 5, "R8 release", int'(tx_msg), 3);
    slot(2, 5, 0, 0, 0, 0);
    chk(limited == 0 && hs_addr == 0 && quota_left == 0 && tx_msg == 2'b10, "R10 return", int'(limited), 0);

    // R8 inactive node forwards at once; R11 foreign grant
    slot(1, 6, 0, 0, 0, 0);
    slot(3, 6, 0, 0, 0, 0);
    chk(tx_msg == 2'b11 && tx_addr == 6, "R8 immediate", int'(tx_msg), 3);
    slot(2, 4, 0, 0, 0, 0);
    chk(limited == 1 && tx_msg == 2'b10 && tx_addr == 4, "R11 foreign grant", int'(limited), 1);
    slot(2, 6, 0, 0, 0, 0);
    chk(limited == 0, "R10 return2", int'(limited), 0);

    // R5 collision: threshold meets incoming request
    repeat (3) slot(0, 0, 1, 0, 0, 0);
    slot(1, 7, 1, 0, 0, 0);
    chk(tail == 0 && hs_addr == 7 && tx_msg == 2'b01 && tx_addr == 7, "R5 priority", int'(hs_addr), 7);
    slot(2, 7, 0, 0, 0, 0);
    repeat (3) slot(0, 0, 1, 0, 0, 0);
    chk(tail == 0, "R5 count cleared", int'(tail), 0);
    slot(0, 0, 1, 0, 0, 0);
    chk(tail == 1, "R5 fresh fire", int'(tail), 1);
    slot(3, 3, 0, 0, 0, 0);

    // R6 deferral behind occupied field
    repeat (3) slot(0, 0, 1, 0, 0, 0);
    slot(3, 9, 1, 0, 0, 0);
    chk(tail == 0 && tx_msg == 2'b11 && tx_addr == 9, "R6 deferred", int'(tail), 0);
    slot(0, 0, 1, 0, 0, 0);
    chk(tail == 1 && tx_msg == 2'b01, "R6 issued", int'(tx_msg), 1);
    slot(2, 3, 0, 0, 0, 0);
    chk(limited == 0, "R10 tail grant", int'(limited), 0);

    // R2 idle cycles
    repeat (4) @(negedge clk);
    chk(tx_msg == 0 && tx_addr == 0, "R2 idle", int'(tx_msg), 0);
    finish_run();
  end
endmodule